// File: doc/BRIEF.md
# Context Identifier Sample Register

This block is one slice of a debug register file. It keeps the context identifier that was live when the most recent program-counter sample was taken. A neighbouring register raises a one-cycle strobe when its low 32-bit word is read. On that strobe, this block copies the current context identifier into a 32-bit holding register. Software on the external debug bus can then read the holding register and find out which address space the sampled PC belonged to.

The copied value comes from one of three live context identifier inputs:

- The 64-bit-state copy, used when the lower privilege level runs in 64-bit mode.
- The secure 32-bit copy, used when that level runs in 32-bit mode, a secure monitor level exists and runs in 32-bit mode, and the sample is flagged secure.
- The non-secure 32-bit copy, used in every other case.

The bus decodes two aliased offsets for the holding register. Every access is refused with an error unless the core is powered and both the double lock and the OS lock are clear. Writes are accepted and discarded. When the block is built without the feature, the holding register reads as zero.

Top module: `ctx_sample_capture`

## Requirements
- R1: The holding register loads on the clock edge where `pcSampleLoRead` is 1. On any edge where it is 0, the register keeps its value, even if the live context inputs change.
- R2: When `el1Is64` is 1, the captured value is `ctxId64`.
- R3: When `el1Is64` is 0, the secure monitor level is present (`EL3_PRESENT`=1), `el3Is32` is 1 and `sampleSecure` is 1, the captured value is `ctxId32Sec`.
- R4: When `el1Is64` is 0 and R3 does not apply, the captured value is `ctxId32Ns`.
- R5: A permitted read at byte address 0x208 or at 0x228 returns the holding register, and both addresses return the same value.
- R6: A read in the same cycle as a capture strobe returns the value from before the capture. The new value is visible from the next cycle.
- R7: An access succeeds only when `corePowered`=1, `doubleLock`=0 and `osLock`=0. Otherwise `busErr` is 1 and `busRdata` is 0, for reads and writes at any address.
- R8: A permitted write to either alias completes with `busErr`=0 and leaves the holding register unchanged.
- R9: Cold reset (`rstN`=0) sets the holding register to `RESET_VALUE`, which defaults to 0.
- R10: With `FEATURE_EN`=0, permitted reads at both aliases return 0 with no error, and capture strobes have no effect.
- R11: A permitted read at any other address returns 0 with `busErr`=0.
- R12: `busReady` is always 1, so every access completes in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Cold reset, active low, asynchronous |
| busValid | input | 1 | Bus access request |
| busReady | output | 1 | Bus accept, always 1 |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address within the monitor block |
| busRdata | output | 32 | Read data, valid in the cycle of the access |
| busErr | output | 1 | Error response for a refused access |
| corePowered | input | 1 | Core power domain is up |
| doubleLock | input | 1 | Double lock is set |
| osLock | input | 1 | OS lock is set |
| pcSampleLoRead | input | 1 | Strobe: the low word of the PC sample is being read |
| el1Is64 | input | 1 | Lower privilege level runs in 64-bit mode |
| el3Is32 | input | 1 | Secure monitor level runs in 32-bit mode |
| sampleSecure | input | 1 | The sample belongs to the secure state |
| ctxId64 | input | 32 | Live context ID, 64-bit state copy |
| ctxId32Sec | input | 32 | Live context ID, 32-bit secure bank |
| ctxId32Ns | input | 32 | Live context ID, 32-bit non-secure bank |

## Verification
The bench walks all eight combinations of the three source-select flags, using several data patterns. A wrong priority between the execution-state flag and the bank flags would capture the wrong live copy, and the bench would see the wrong identifier at both aliases. It strobes a capture and reads in the same cycle, which exposes a design that forwards the new value early and so breaks R6. It changes the live inputs without a strobe to catch a register that loads continuously. It sweeps the power and lock inputs for reads and writes at both aliases. A gate that ignores one lock, or a write that clobbers the register, would show up there. A second instance built without the feature must read zero after captures.

// File: rtl/ctx_sample_pkg.sv
package ctx_sample_pkg;

  typedef struct packed {
    logic capture;
    logic readSel;
    logic accessErr;
  } ctrlStrobes_t;

endpackage

// File: rtl/ctx_sample_ctrl.sv
module ctx_sample_ctrl
  import ctx_sample_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] ALIAS_A = 12'h208,
  parameter logic [ADDR_W-1:0] ALIAS_B = 12'h228
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              corePowered,
  input  logic              doubleLock,
  input  logic              osLock,
  input  logic              pcSampleLoRead,
  output logic              busReady,
  output ctrlStrobes_t      strobes
);

  localparam int NUM_ALIAS = 2;
  localparam logic [NUM_ALIAS*ADDR_W-1:0] ALIAS_LIST = {ALIAS_B, ALIAS_A};

  logic [NUM_ALIAS-1:0] aliasHit;
  logic accessOk;
  logic anyHit;

  for (genvar i = 0; i < NUM_ALIAS; i++) begin : g_alias
    assign aliasHit[i] = (busAddr == ALIAS_LIST[i*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    accessOk = corePowered && !doubleLock && !osLock;
    anyHit   = |aliasHit;
    strobes.accessErr = busValid && !accessOk;
    strobes.readSel   = busValid && !busWrite && accessOk && anyHit;
    strobes.capture   = pcSampleLoRead;
  end

  assign busReady = 1'b1;

endmodule

// File: rtl/ctx_sample_dp.sv
module ctx_sample_dp
  import ctx_sample_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter bit EL3_PRESENT = 1'b1,
  parameter bit FEATURE_EN  = 1'b1,
  parameter logic [DATA_W-1:0] RESET_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              el1Is64,
  input  logic              el3Is32,
  input  logic              sampleSecure,
  input  logic [DATA_W-1:0] ctxId64,
  input  logic [DATA_W-1:0] ctxId32Sec,
  input  logic [DATA_W-1:0] ctxId32Ns,
  output logic [DATA_W-1:0] sampleVal,
  output logic [DATA_W-1:0] busRdata
);

  logic              useSecBank;
  logic [DATA_W-1:0] srcCtx;

  if (EL3_PRESENT) begin : g_banked
    assign useSecBank = el3Is32 && sampleSecure;
  end else begin : g_flat
    assign useSecBank = 1'b0;
  end

  always_comb begin
    if (el1Is64)         srcCtx = ctxId64;
    else if (useSecBank) srcCtx = ctxId32Sec;
    else                 srcCtx = ctxId32Ns;
  end

  if (FEATURE_EN) begin : g_present
    logic [DATA_W-1:0] sampleQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                sampleQ <= RESET_VALUE;
      else if (strobes.capture) sampleQ <= srcCtx;
    end
    assign sampleVal = sampleQ;
  end else begin : g_absent
    assign sampleVal = '0;
  end

  assign busRdata = (strobes.readSel && !strobes.accessErr) ? sampleVal : '0;

endmodule

// File: rtl/ctx_sample_capture.sv
module ctx_sample_capture
  import ctx_sample_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter bit EL3_PRESENT = 1'b1,
  parameter bit FEATURE_EN  = 1'b1,
  parameter logic [ADDR_W-1:0] ALIAS_A = 12'h208,
  parameter logic [ADDR_W-1:0] ALIAS_B = 12'h228,
  parameter logic [DATA_W-1:0] RESET_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  output logic              busReady,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  input  logic              corePowered,
  input  logic              doubleLock,
  input  logic              osLock,
  input  logic              pcSampleLoRead,
  input  logic              el1Is64,
  input  logic              el3Is32,
  input  logic              sampleSecure,
  input  logic [DATA_W-1:0] ctxId64,
  input  logic [DATA_W-1:0] ctxId32Sec,
  input  logic [DATA_W-1:0] ctxId32Ns
);

  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] sampleVal;

  ctx_sample_ctrl #(
    .ADDR_W (ADDR_W),
    .ALIAS_A(ALIAS_A),
    .ALIAS_B(ALIAS_B)
  ) ctrl_i (
    .busValid      (busValid),
    .busWrite      (busWrite),
    .busAddr       (busAddr),
    .corePowered   (corePowered),
    .doubleLock    (doubleLock),
    .osLock        (osLock),
    .pcSampleLoRead(pcSampleLoRead),
    .busReady      (busReady),
    .strobes       (strobes)
  );

  ctx_sample_dp #(
    .DATA_W     (DATA_W),
    .EL3_PRESENT(EL3_PRESENT),
    .FEATURE_EN (FEATURE_EN),
    .RESET_VALUE(RESET_VALUE)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .el1Is64     (el1Is64),
    .el3Is32     (el3Is32),
    .sampleSecure(sampleSecure),
    .ctxId64     (ctxId64),
    .ctxId32Sec  (ctxId32Sec),
    .ctxId32Ns   (ctxId32Ns),
    .sampleVal   (sampleVal),
    .busRdata    (busRdata)
  );

  assign busErr = strobes.accessErr;

endmodule

// File: rtl/ctx_sample_chk.sv
module ctx_sample_chk #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter bit EL3_PRESENT = 1'b1,
  parameter bit FEATURE_EN  = 1'b1,
  parameter logic [ADDR_W-1:0] ALIAS_A = 12'h208,
  parameter logic [ADDR_W-1:0] ALIAS_B = 12'h228
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busReady,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              busErr,
  input logic              corePowered,
  input logic              doubleLock,
  input logic              osLock,
  input logic              pcSampleLoRead,
  input logic              el1Is64,
  input logic              el3Is32,
  input logic              sampleSecure,
  input logic [DATA_W-1:0] ctxId64,
  input logic [DATA_W-1:0] ctxId32Sec,
  input logic [DATA_W-1:0] ctxId32Ns,
  input logic [DATA_W-1:0] sampleVal
);

  a_r12_always_ready: assert property (@(posedge clk) disable iff (!rstN)
    busReady);

  a_r7_refuse: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !(corePowered && !doubleLock && !osLock) |-> busErr && busRdata == '0);

  a_r8_write_ok: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && corePowered && !doubleLock && !osLock |-> !busErr);

  a_r5_alias_read: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite && !busErr && (busAddr == ALIAS_A || busAddr == ALIAS_B)
      |-> busRdata == sampleVal);

  a_r11_unmapped: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busErr && busAddr != ALIAS_A && busAddr != ALIAS_B |-> busRdata == '0);

  if (FEATURE_EN) begin : g_cap
    a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
      !pcSampleLoRead |=> $stable(sampleVal));

    a_r2_src64: assert property (@(posedge clk) disable iff (!rstN)
      pcSampleLoRead && el1Is64 |=> sampleVal == $past(ctxId64));

    a_r4_src_ns: assert property (@(posedge clk) disable iff (!rstN)
      pcSampleLoRead && !el1Is64 && !(EL3_PRESENT && el3Is32 && sampleSecure)
        |=> sampleVal == $past(ctxId32Ns));

    if (EL3_PRESENT) begin : g_bank
      a_r3_src_sec: assert property (@(posedge clk) disable iff (!rstN)
        pcSampleLoRead && !el1Is64 && el3Is32 && sampleSecure
          |=> sampleVal == $past(ctxId32Sec));
    end
  end else begin : g_nocap
    a_r10_absent_zero: assert property (@(posedge clk) disable iff (!rstN)
      sampleVal == '0 && busRdata == '0);
  end

endmodule

bind ctx_sample_capture ctx_sample_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .EL3_PRESENT(EL3_PRESENT),
  .FEATURE_EN (FEATURE_EN),
  .ALIAS_A    (ALIAS_A),
  .ALIAS_B    (ALIAS_B)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .busValid      (busValid),
  .busReady      (busReady),
  .busWrite      (busWrite),
  .busAddr       (busAddr),
  .busRdata      (busRdata),
  .busErr        (busErr),
  .corePowered   (corePowered),
  .doubleLock    (doubleLock),
  .osLock        (osLock),
  .pcSampleLoRead(pcSampleLoRead),
  .el1Is64       (el1Is64),
  .el3Is32       (el3Is32),
  .sampleSecure  (sampleSecure),
  .ctxId64       (ctxId64),
  .ctxId32Sec    (ctxId32Sec),
  .ctxId32Ns     (ctxId32Ns),
  .sampleVal     (sampleVal)
);

// File: tb/ctx_sample_capture_tb_top.sv
module ctx_sample_capture_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic        corePowered = 1'b1;
  logic        doubleLock = 1'b0;
  logic        osLock = 1'b0;
  logic        pcSampleLoRead = 1'b0;
  logic        el1Is64 = 1'b0;
  logic        el3Is32 = 1'b0;
  logic        sampleSecure = 1'b0;
  logic [31:0] ctxId64 = '0;
  logic [31:0] ctxId32Sec = '0;
  logic [31:0] ctxId32Ns = '0;

  logic        busReady, busErr, busReadyAbs, busErrAbs;
  logic [31:0] busRdata, busRdataAbs;

  int checks = 0;
  int fails  = 0;
  logic [31:0] curSample = '0;

  always #2.5 clk = ~clk;

  ctx_sample_capture dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busReady(busReady),
    .busWrite(busWrite), .busAddr(busAddr), .busRdata(busRdata), .busErr(busErr),
    .corePowered(corePowered), .doubleLock(doubleLock), .osLock(osLock),
    .pcSampleLoRead(pcSampleLoRead), .el1Is64(el1Is64), .el3Is32(el3Is32),
    .sampleSecure(sampleSecure), .ctxId64(ctxId64), .ctxId32Sec(ctxId32Sec),
    .ctxId32Ns(ctxId32Ns)
  );

  ctx_sample_capture #(.FEATURE_EN(1'b0)) dut_absent_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busReady(busReadyAbs),
    .busWrite(busWrite), .busAddr(busAddr), .busRdata(busRdataAbs), .busErr(busErrAbs),
    .corePowered(corePowered), .doubleLock(doubleLock), .osLock(osLock),
    .pcSampleLoRead(pcSampleLoRead), .el1Is64(el1Is64), .el3Is32(el3Is32),
    .sampleSecure(sampleSecure), .ctxId64(ctxId64), .ctxId32Sec(ctxId32Sec),
    .ctxId32Ns(ctxId32Ns)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expCtx(input logic e64, input logic e3, input logic sec,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c);
    if (e64)           return a;
    else if (e3 && sec) return b;
    else               return c;
  endfunction

  // Called at a falling edge; drives the access, samples, returns at the next falling edge.
  task automatic access(input logic wr, input logic [11:0] addr,
                        output logic [31:0] rd, output logic err,
                        output logic [31:0] rdA, output logic errA);
    busValid = 1'b1; busWrite = wr; busAddr = addr;
    #1;
    rd = busRdata; err = busErr; rdA = busRdataAbs; errA = busErrAbs;
    checkEq("R12 ready", {31'd0, busReady}, 32'd1);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doCapture();
    pcSampleLoRead = 1'b1;
    @(negedge clk);
    pcSampleLoRead = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, rdA;
    logic err, errA;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: cold reset value
    access(1'b0, 12'h208, rd, err, rdA, errA);
    checkEq("R9 reset value", rd, 32'h0);
    checkEq("R9 reset err", {31'd0, err}, 32'd0);

    // R2 R3 R4: all source-select combinations, several patterns; R5 both aliases
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] a, b, c, e;
        a = 32'hA5000000 ^ (32'(m) << 8) ^ (32'(p) * 32'h01010101);
        b = 32'hB6000000 ^ (32'(m) << 12) ^ (32'(p) * 32'h00110011);
        c = 32'hC7000000 ^ (32'(m) << 4) ^ (32'(p) * 32'h10001000);
        el1Is64 = m[0]; el3Is32 = m[1]; sampleSecure = m[2];
        ctxId64 = a; ctxId32Sec = b; ctxId32Ns = c;
        e = expCtx(m[0], m[1], m[2], a, b, c);
        doCapture();
        curSample = e;
        access(1'b0, 12'h208, rd, err, rdA, errA);
        if (m[0])              checkEq("R2 source 64", rd, e);
        else if (m[1] && m[2]) checkEq("R3 secure bank", rd, e);
        else                   checkEq("R4 nonsecure bank", rd, e);
        access(1'b0, 12'h228, rd, err, rdA, errA);
        checkEq("R5 alias 0x228", rd, e);
        checkEq("R10 absent reads zero", rdA, 32'h0);
        checkEq("R10 absent no err", {31'd0, errA}, 32'd0);
      end
    end

    // R1: live inputs change without strobe, value held
    ctxId64 = 32'h11111111; ctxId32Sec = 32'h22222222; ctxId32Ns = 32'h33333333;
    el1Is64 = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 12'h208, rd, err, rdA, errA);
    checkEq("R1 hold without strobe", rd, curSample);

    // R6: read in the capture cycle returns the old value
    busValid = 1'b1; busWrite = 1'b0; busAddr = 12'h228;
    pcSampleLoRead = 1'b1;
    #1;
    checkEq("R6 same-cycle old value", busRdata, curSample);
    @(negedge clk);
    pcSampleLoRead = 1'b0;
    curSample = 32'h11111111;
    #1;
    checkEq("R1 new value next cycle", busRdata, curSample);
    @(negedge clk);
    busValid = 1'b0;

    // R8: permitted writes do nothing and complete cleanly
    access(1'b1, 12'h208, rd, err, rdA, errA);
    checkEq("R8 write no err 0x208", {31'd0, err}, 32'd0);
    access(1'b1, 12'h228, rd, err, rdA, errA);
    checkEq("R8 write no err 0x228", {31'd0, err}, 32'd0);
    access(1'b0, 12'h208, rd, err, rdA, errA);
    checkEq("R8 value unchanged after writes", rd, curSample);

    // R11: unmapped address
    access(1'b0, 12'h20C, rd, err, rdA, errA);
    checkEq("R11 unmapped data", rd, 32'h0);
    checkEq("R11 unmapped err", {31'd0, err}, 32'd0);

    // R7: gating sweep over power and both locks, reads and writes, both aliases
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 4; k++) begin
        logic ok;
        logic [11:0] ad;
        corePowered = g[0]; doubleLock = g[1]; osLock = g[2];
        ok = g[0] && !g[1] && !g[2];
        ad = k[0] ? 12'h228 : 12'h208;
        access(k[1], ad, rd, err, rdA, errA);
        checkEq("R7 error flag", {31'd0, err}, {31'd0, !ok});
        checkEq("R7 read data", rd, (ok && !k[1]) ? curSample : 32'h0);
      end
    end
    corePowered = 1'b1; doubleLock = 1'b0; osLock = 1'b0;
    access(1'b0, 12'h208, rd, err, rdA, errA);
    checkEq("R7 refused accesses left value", rd, curSample);

    // R9: cold reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    access(1'b0, 12'h228, rd, err, rdA, errA);
    checkEq("R9 value after cold reset", rd, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule